// File: doc/BRIEF.md
# Prescaled match/capture timer

A timer/counter block on a small synchronous register bus. A prescale counter divides the clock: it counts up to a programmed limit, then wraps, and on each wrap the main timer counter advances by one. Four compare channels watch the main counter. When the count equals a compare value, each channel can, on its own settings, raise an interrupt flag, send the counter back to zero, or halt counting.

Two capture inputs are synchronized and edge-detected. On a selected edge, each one copies the main counter into its own read-only capture register. A capture can also raise its own interrupt flag. Software reads the pending flags from one register and clears them by writing ones to it. The interrupt line is high while any flag is set.

Top module: `pmt_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: While enabled (control bit 0 = 1, bit 1 = 0), the prescale counter runs 0,1,...,PR. The clock after it equals PR, it returns to 0 and the timer counter increments, so the timer counter advances once every PR+1 clocks.
- R3: Control bit 1 holds both counters at zero for as long as it is set. With bit 0 clear, both counters keep their value.
- R4: The bus uses byte offsets, decoded on bits 7:2. The map is 0x00 flags, 0x04 control, 0x08 timer counter, 0x0C prescale limit, 0x10 prescale counter, 0x14 match control, 0x18/0x1C/0x20/0x24 compare 0..3, 0x28 capture control, 0x2C/0x30 capture 0..1. All of these read back what was last written. Any other offset reads zero.
- R5: A compare event happens on the clock where the prescale counter wraps while the timer counter equals compare value k. If match-control bit 3k is set, that event sets flag bit k.
- R6: If match-control bit 3k+1 is set, the timer counter goes to 0 on that event instead of going to the compare value plus one.
- R7: If match-control bit 3k+2 is set, the event keeps the timer counter where it is, clears the prescale counter and clears control bit 0.
- R8: Capture inputs pass through two synchronizer flops before edge detection. Capture-control bit 3k selects rising edges for input k and bit 3k+1 selects falling edges. On a selected edge, capture register k loads the timer counter three clocks after the input changes. Writes to capture registers are ignored.
- R9: If capture-control bit 3k+2 is set, a capture on input k sets flag bit 4+k.
- R10: Writing the flags register clears each bit written as 1 and leaves bits written as 0. `irq_o` is the OR of all flags.
- R11: The timer counter wraps from 0xFFFF to 0x0000 on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the offset |
| cap_i | input | 2 | Asynchronous capture inputs |
| irq_o | output | 1 | Any flag pending |

## Verification
The bench builds the block with the default 16-bit counter width. At that width the wrap from 0xFFFF to 0 can be reached by loading the counter with 0xFFFE. Prescale limits of 0 and 2 keep every tick at a cycle the bench can count exactly. Capture tests run with counting disabled, so the captured value is the one loaded over the bus regardless of the synchronizer delay.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int N_MATCH = 4;
  localparam int N_CAP   = 2;
  localparam int MCR_W   = 3 * N_MATCH;
  localparam int CCR_W   = 3 * N_CAP;
  localparam int IR_W    = N_MATCH + N_CAP;
  localparam int WORD_W  = ADDR_W - 2;

  localparam logic [WORD_W-1:0] W_IR   = 6'd0;
  localparam logic [WORD_W-1:0] W_CTL  = 6'd1;
  localparam logic [WORD_W-1:0] W_TC   = 6'd2;
  localparam logic [WORD_W-1:0] W_PR   = 6'd3;
  localparam logic [WORD_W-1:0] W_PC   = 6'd4;
  localparam logic [WORD_W-1:0] W_MCR  = 6'd5;
  localparam logic [WORD_W-1:0] W_MR0  = 6'd6;
  localparam logic [WORD_W-1:0] W_CCR  = 6'd10;
  localparam logic [WORD_W-1:0] W_CR0  = 6'd11;
endpackage

// File: rtl/pmt_count.sv
module pmt_count #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          hold_i,
  input  logic [TW-1:0] pr_i,
  input  logic          mrst_i,
  input  logic          mstop_i,
  input  logic          wr_tc_i,
  input  logic          wr_pc_i,
  input  logic [TW-1:0] wdata_i,
  output logic [TW-1:0] tc_o,
  output logic [TW-1:0] pc_o,
  output logic          tick_o
);
  logic [TW-1:0] tc_q, pc_q;

  assign tick_o = en_i && !hold_i && (pc_q == pr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (hold_i) begin
      tc_q <= '0;
      pc_q <= '0;
    end else begin
      if (wr_pc_i)     pc_q <= wdata_i;
      else if (tick_o) pc_q <= '0;
      else if (en_i)   pc_q <= pc_q + 1'b1;

      if (wr_tc_i) tc_q <= wdata_i;
      else if (tick_o) begin
        if (mrst_i)        tc_q <= '0;
        else if (!mstop_i) tc_q <= tc_q + 1'b1;
      end
    end
  end

  assign tc_o = tc_q;
  assign pc_o = pc_q;

  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (tc_q == '0 && pc_q == '0)); // R3

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !hold_i && !wr_tc_i) |=> $stable(tc_q)); // R3

  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !mrst_i && !mstop_i && !wr_tc_i) |=> tc_q == TW'($past(tc_q) + 1'b1)); // R2
endmodule

// File: rtl/pmt_match.sv
module pmt_match
  import pmt_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic                        tick_i,
  input  logic [TW-1:0]               tc_i,
  input  logic [N_MATCH-1:0][TW-1:0]  mr_i,
  input  logic [MCR_W-1:0]            mcr_i,
  output logic [N_MATCH-1:0]          irq_set_o,
  output logic                        rst_req_o,
  output logic                        stop_req_o
);
  logic [N_MATCH-1:0] hit, want_rst, want_stop;

  for (genvar k = 0; k < N_MATCH; k++) begin : g_ch
    assign hit[k]       = tick_i && (tc_i == mr_i[k]);
    assign irq_set_o[k] = hit[k] && mcr_i[3*k];
    assign want_rst[k]  = hit[k] && mcr_i[3*k+1];
    assign want_stop[k] = hit[k] && mcr_i[3*k+2];
  end

  assign rst_req_o  = |want_rst;
  assign stop_req_o = |want_stop;
endmodule

// File: rtl/pmt_capture.sv
module pmt_capture
  import pmt_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CAP-1:0]          cap_i,
  input  logic [CCR_W-1:0]          ccr_i,
  input  logic [TW-1:0]             tc_i,
  output logic [N_CAP-1:0][TW-1:0]  cr_o,
  output logic [N_CAP-1:0]          irq_set_o
);
  logic [N_CAP-1:0] s1_q, s2_q, prev_q, evt;
  logic [N_CAP-1:0][TW-1:0] cr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= cap_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar k = 0; k < N_CAP; k++) begin : g_ch
    assign evt[k] = (ccr_i[3*k]   && s2_q[k] && !prev_q[k]) ||
                    (ccr_i[3*k+1] && !s2_q[k] && prev_q[k]);
    assign irq_set_o[k] = evt[k] && ccr_i[3*k+2];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cr_q[k] <= '0;
      else if (evt[k]) cr_q[k] <= tc_i;
    end

    AST_CAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt[k] |=> cr_q[k] == $past(tc_i)); // R8
  end

  assign cr_o = cr_q;
endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
  import pmt_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [1:0]        cap_i,
  output logic              irq_o
);
  logic [WORD_W-1:0] word;
  logic wr;
  logic [1:0] ctl_q;
  logic [TW-1:0] pr_q, tc, pc;
  logic [MCR_W-1:0] mcr_q;
  logic [CCR_W-1:0] ccr_q;
  logic [N_MATCH-1:0][TW-1:0] mr_q;
  logic [N_CAP-1:0][TW-1:0] cr;
  logic [IR_W-1:0] ir_q, ir_clr, ir_set;
  logic [N_MATCH-1:0] m_set;
  logic [N_CAP-1:0] c_set;
  logic tick, m_rst, m_stop, ctl_wr;
  logic unused_bits;

  assign word   = bus_addr_i[ADDR_W-1:2];
  assign wr     = bus_sel_i && bus_we_i;
  assign ctl_wr = wr && word == W_CTL;
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[DATA_W-1:TW]};

  pmt_count #(.TW(TW)) u_count (
    .clk_i, .rst_ni,
    .en_i    (ctl_q[0]),
    .hold_i  (ctl_q[1]),
    .pr_i    (pr_q),
    .mrst_i  (m_rst),
    .mstop_i (m_stop),
    .wr_tc_i (wr && word == W_TC),
    .wr_pc_i (wr && word == W_PC),
    .wdata_i (bus_wdata_i[TW-1:0]),
    .tc_o    (tc),
    .pc_o    (pc),
    .tick_o  (tick)
  );

  pmt_match #(.TW(TW)) u_match (
    .tick_i     (tick),
    .tc_i       (tc),
    .mr_i       (mr_q),
    .mcr_i      (mcr_q),
    .irq_set_o  (m_set),
    .rst_req_o  (m_rst),
    .stop_req_o (m_stop)
  );

  pmt_capture #(.TW(TW)) u_capture (
    .clk_i, .rst_ni,
    .cap_i,
    .ccr_i     (ccr_q),
    .tc_i      (tc),
    .cr_o      (cr),
    .irq_set_o (c_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      pr_q  <= '0;
      mcr_q <= '0;
      ccr_q <= '0;
      mr_q  <= '0;
    end else begin
      if (ctl_wr)      ctl_q <= bus_wdata_i[1:0];
      else if (m_stop) ctl_q[0] <= 1'b0;
      if (wr && word == W_PR)  pr_q  <= bus_wdata_i[TW-1:0];
      if (wr && word == W_MCR) mcr_q <= bus_wdata_i[MCR_W-1:0];
      if (wr && word == W_CCR) ccr_q <= bus_wdata_i[CCR_W-1:0];
      for (int k = 0; k < N_MATCH; k++)
        if (wr && word == WORD_W'(W_MR0 + k)) mr_q[k] <= bus_wdata_i[TW-1:0];
    end
  end

  // set wins over clear so a same-cycle event is not lost
  assign ir_clr = (wr && word == W_IR) ? bus_wdata_i[IR_W-1:0] : '0;
  assign ir_set = {c_set, m_set};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ir_q <= '0;
    else         ir_q <= (ir_q & ~ir_clr) | ir_set;
  end

  assign irq_o = |ir_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      unique case (word)
        W_IR:    bus_rdata_o[IR_W-1:0]  = ir_q;
        W_CTL:   bus_rdata_o[1:0]       = ctl_q;
        W_TC:    bus_rdata_o[TW-1:0]    = tc;
        W_PR:    bus_rdata_o[TW-1:0]    = pr_q;
        W_PC:    bus_rdata_o[TW-1:0]    = pc;
        W_MCR:   bus_rdata_o[MCR_W-1:0] = mcr_q;
        W_CCR:   bus_rdata_o[CCR_W-1:0] = ccr_q;
        default: begin
          for (int k = 0; k < N_MATCH; k++)
            if (word == WORD_W'(W_MR0 + k)) bus_rdata_o[TW-1:0] = mr_q[k];
          for (int k = 0; k < N_CAP; k++)
            if (word == WORD_W'(W_CR0 + k)) bus_rdata_o[TW-1:0] = cr[k];
        end
      endcase
    end
  end

  AST_STOP_CLEARS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_stop && !ctl_wr) |=> !ctl_q[0]); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ir_q & ~ir_clr)) |=> ((ir_q & $past(ir_q & ~ir_clr)) == $past(ir_q & ~ir_clr))); // R10

  AST_MATCH_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_rst && !(wr && word == W_TC) && !ctl_q[1]) |=> tc == '0); // R6
endmodule

// File: tb/pmt_timer_bench.sv
module pmt_timer_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [7:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, bus_rdata_o;
  logic [1:0] cap_i = '0;
  logic irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  bit          irq_q[$];
  string       tag_q[$];
  event        rd_ev;

  always #5 clk = ~clk;

  pmt_timer u_pmt_timer (
    .clk_i(clk), .rst_ni, .bus_sel_i, .bus_we_i, .bus_addr_i,
    .bus_wdata_i, .bus_rdata_o, .cap_i, .irq_o
  );

  // monitor: pops expected items and compares the observed port
  initial forever begin
    @(rd_ev);
    if (exp_q.size() != 0) begin
      logic [31:0] e, a;
      bit is_irq;
      string t;
      e = exp_q.pop_front();
      is_irq = irq_q.pop_front();
      t = tag_q.pop_front();
      a = is_irq ? {31'd0, irq_o} : bus_rdata_o;
      n_run++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s act=%h exp=%h", t, a, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 0; bus_we_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_sel_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1;
    exp_q.push_back(e); irq_q.push_back(1'b0); tag_q.push_back(t);
    ->rd_ev;
    @(negedge clk);
    bus_sel_i = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    #1;
    exp_q.push_back({31'd0, e}); irq_q.push_back(1'b1); tag_q.push_back(t);
    ->rd_ev;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1;
    idle(1);
    // R1 reset state
    rd(8'h00, 0, "R1 flags");
    rd(8'h04, 0, "R1 control");
    rd(8'h08, 0, "R1 timer");
    rd(8'h14, 0, "R1 match ctl");
    rd(8'h2C, 0, "R1 capture0");
    chk_irq(0, "R1 irq");

    // R2 PR=0: one step per clock
    wr(8'h04, 1);
    idle(5);
    rd(8'h08, 5, "R2 pr0 count");
    wr(8'h04, 0);
    idle(3);
    rd(8'h08, 7, "R3 disabled hold");

    // R2 PR=2
    wr(8'h04, 2);
    wr(8'h0C, 2);
    wr(8'h04, 1);
    idle(7);
    rd(8'h08, 2, "R2 pr2 timer");
    rd(8'h10, 2, "R2 pr2 prescale");
    wr(8'h04, 0);
    rd(8'h08, 3, "R2 pr2 timer after");
    rd(8'h10, 1, "R2 pr2 prescale after");

    // R3 hold in reset while enabled
    wr(8'h04, 3);
    idle(3);
    rd(8'h08, 0, "R3 hold timer");
    rd(8'h10, 0, "R3 hold prescale");
    wr(8'h04, 0);

    // R4 register access
    wr(8'h08, 32'h1234);
    rd(8'h08, 32'h1234, "R4 timer rw");
    wr(8'h10, 7);
    rd(8'h10, 7, "R4 prescale rw");
    wr(8'h20, 32'hBEEF);
    rd(8'h20, 32'hBEEF, "R4 compare2 rw");
    wr(8'h14, 32'h0ABC);
    rd(8'h14, 32'h0ABC, "R4 match ctl rw");
    rd(8'h3C, 0, "R4 unmapped");

    // R5 R6 match interrupt + reset, PR=0
    wr(8'h0C, 0);
    wr(8'h04, 2);
    wr(8'h18, 3);
    wr(8'h14, 32'h3);
    wr(8'h04, 1);
    idle(4);
    rd(8'h00, 32'h1, "R5 match flag");
    rd(8'h08, 1, "R6 wrapped at compare");
    chk_irq(1, "R10 irq high");
    wr(8'h04, 0);
    wr(8'h00, 0);
    rd(8'h00, 32'h1, "R10 zero write keeps");
    wr(8'h00, 1);
    rd(8'h00, 0, "R10 one clears");
    chk_irq(0, "R10 irq low");

    // R7 stop on compare1 = 5
    wr(8'h04, 2);
    wr(8'h1C, 5);
    wr(8'h14, 32'h28);
    wr(8'h04, 1);
    idle(10);
    rd(8'h04, 0, "R7 enable cleared");
    rd(8'h08, 5, "R7 timer held");
    rd(8'h10, 0, "R7 prescale cleared");
    rd(8'h00, 32'h2, "R7 flag");
    wr(8'h00, 32'h3F);

    // R11 wrap
    wr(8'h14, 0);
    wr(8'h08, 32'hFFFE);
    wr(8'h04, 1);
    idle(1);
    rd(8'h08, 32'hFFFF, "R11 top");
    rd(8'h08, 0, "R11 wrap");
    wr(8'h04, 0);

    // R8 R9 capture, counting stopped
    wr(8'h08, 32'h42);
    wr(8'h28, 32'h1D);
    cap_i[0] = 1;
    idle(4);
    rd(8'h2C, 32'h42, "R8 rising capture");
    rd(8'h00, 32'h10, "R9 capture flag");
    wr(8'h08, 32'h55);
    cap_i[0] = 0;
    idle(4);
    rd(8'h2C, 32'h42, "R8 falling ignored");
    cap_i[1] = 1;
    idle(4);
    rd(8'h30, 32'h55, "R8 both rise");
    wr(8'h08, 32'h66);
    cap_i[1] = 0;
    idle(4);
    rd(8'h30, 32'h66, "R8 both fall");
    rd(8'h00, 32'h10, "R9 no flag without enable");
    wr(8'h2C, 32'hBEEF);
    rd(8'h2C, 32'h42, "R8 capture write ignored");

    // R8 latency: changes at the third edge
    wr(8'h08, 32'h77);
    cap_i[0] = 1;
    idle(2);
    rd(8'h2C, 32'h42, "R8 not yet");
    rd(8'h2C, 32'h77, "R8 third edge");

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule